// File: doc/BRIEF.md
# Limit-Checked Downward Hardware Stack

This block keeps a last-in, first-out stack of return addresses or data words in a small internal memory. The stack starts at a programmable top address and grows toward lower addresses. Each push moves the pointer down by one. Each pop reads the newest entry and moves the pointer back up. Two limit registers bound the region the stack may occupy. Every request is checked against them in hardware, so software never has to test for room before a push or for data before a pop.

A request that would leave the region is refused. The block raises a one-cycle exception pulse, either overflow or underflow, and leaves the pointer and the stored words as they were. A push and a pop in the same cycle swap the top word: the pop returns the old word and the pushed word replaces it. The limits can be rewritten only in a cycle with no push or pop. A new setting takes effect on the following cycle and empties the stack.

Top module: `hw_stack_lim`

## Requirements
- R1: After reset the pointer equals the top limit (default 31). The bottom limit defaults to 0. Empty is 1, full is 0, and no exception or read-valid strobe is high.
- R2: A push alone on a stack that is not full writes the word and lowers the pointer by one. The pointer is visible on the cycle after the request.
- R3: A pop alone on a non-empty stack raises read-valid for one cycle, on the cycle after the request, with the most recently pushed word that has not yet been popped. The pointer rises by one.
- R4: A push alone while full raises the overflow pulse for exactly one cycle, on the next cycle. The pointer and all stored words stay unchanged.
- R5: A pop while empty raises the underflow pulse for exactly one cycle, on the next cycle. It gives no read-valid and leaves the pointer unchanged.
- R6: Empty is high exactly when the pointer equals the top limit. Full is high exactly when the pointer equals the bottom limit. The pointer never leaves the range from the bottom limit to the top limit.
- R7: A push and a pop together on a non-empty stack return the old top word with read-valid, store the new word in its place, and keep the pointer unchanged.
- R8: A push and a pop together on an empty stack count as an underflow, and nothing is stored.
- R9: A limit write in a cycle with no push or pop, and with bottom not above top, loads both limits. From the next cycle the pointer equals the new top, so the stack is empty.
- R10: A limit write is ignored if a push or a pop is requested in the same cycle, or if the requested bottom is above the requested top.
- R11: The stack holds exactly top minus bottom words. When the two limits are equal, full and empty are both high, a push overflows and a pop underflows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_req | input | 1 | Push request |
| push_data | input | DW | Word to push |
| pop_req | input | 1 | Pop request |
| pop_data | output | DW | Word returned by a pop, valid with pop_valid |
| pop_valid | output | 1 | One-cycle strobe: pop_data holds a popped word |
| cfg_we | input | 1 | Limit write strobe |
| cfg_upper | input | AW | New top limit (empty pointer value) |
| cfg_lower | input | AW | New bottom limit (full pointer value) |
| sp | output | AW | Current stack pointer |
| full | output | 1 | No room for another push |
| empty | output | 1 | No word to pop |
| ovf_exc | output | 1 | One-cycle overflow exception pulse |
| udf_exc | output | 1 | One-cycle underflow exception pulse |

## Verification
The bench fills a narrowed region to its bottom limit and then pushes once more. A design that let that push through would store below the region, and the following pops would return the stray word first. The bench also pushes and pops together on both an empty stack and a filled one. A wrong design would either store a word into an empty stack or return the new word in place of the old top. Limits are set equal, and limit writes are attempted alongside a push and with bottom above top. A design that ignored the busy or ordering guard would move the pointer to a bogus top. A long random run compares every popped word against a queue-based model.

// File: rtl/hw_stack_pkg.sv
// Package: shared types for the limit-checked hardware stack.
// Assumes nothing beyond IEEE 1800-2017 synthesis support for enums.
package hw_stack_pkg;

    // Kind of access performed in one cycle, after limit checking.
    typedef enum logic [2:0] {
        ACC_IDLE  = 3'd0,
        ACC_PUSH  = 3'd1,
        ACC_POP   = 3'd2,
        ACC_SWAP  = 3'd3,
        ACC_OVF   = 3'd4,
        ACC_UDF   = 3'd5
    } acc_e;

endpackage

// File: rtl/stack_limits.sv
// Module: stack_limits
// Holds the top and bottom limit registers. A write is accepted only when no
// push or pop is requested in that cycle and the bottom is not above the top.
// Assumes the caller reloads the pointer from cfg_upper when cfg_accept is high.
module stack_limits #(
    parameter int AW         = 5,
    parameter int UPPER_INIT = 31,
    parameter int LOWER_INIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          busy,
    input  logic [AW-1:0] cfg_upper,
    input  logic [AW-1:0] cfg_lower,
    output logic [AW-1:0] upper,
    output logic [AW-1:0] lower,
    output logic          cfg_accept
);

    localparam logic [AW-1:0] UP_RST = AW'(UPPER_INIT);
    localparam logic [AW-1:0] LO_RST = AW'(LOWER_INIT);

    // Decide whether this cycle's limit write is legal.
    always_comb begin
        cfg_accept = cfg_we && !busy && (cfg_lower <= cfg_upper);
    end

    // Load the limits on an accepted write; restore defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper <= UP_RST;
            lower <= LO_RST;
        end else if (cfg_accept) begin
            upper <= cfg_upper;
            lower <= cfg_lower;
        end
    end

endmodule

// File: rtl/stack_ctrl.sv
// Module: stack_ctrl
// Owns the downward-growing stack pointer. Classifies each request against
// the limits, raises one-cycle exception pulses on refused requests, and
// drives the write and read strobes for the storage.
// Assumes lower <= upper (enforced by stack_limits).
module stack_ctrl
    import hw_stack_pkg::*;
#(
    parameter int AW         = 5,
    parameter int UPPER_INIT = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic [AW-1:0] upper,
    input  logic [AW-1:0] lower,
    input  logic          cfg_accept,
    input  logic [AW-1:0] cfg_upper,
    output logic [AW-1:0] sp,
    output logic          full,
    output logic          empty,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          ovf_exc,
    output logic          udf_exc
);

    localparam logic [AW-1:0] SP_RST = AW'(UPPER_INIT);
    localparam logic [AW-1:0] ONE    = AW'(1);

    acc_e          acc;
    logic [AW-1:0] sp_nxt;

    // Occupancy flags from the pointer and the limits.
    always_comb begin
        full  = (sp == lower);
        empty = (sp == upper);
    end

    // Classify the request; underflow wins when a pop meets an empty stack.
    always_comb begin
        unique case ({push_req, pop_req})
            2'b10:   acc = full  ? ACC_OVF : ACC_PUSH;
            2'b01:   acc = empty ? ACC_UDF : ACC_POP;
            2'b11:   acc = empty ? ACC_UDF : ACC_SWAP;
            default: acc = ACC_IDLE;
        endcase
    end

    // Storage strobes and next pointer for the chosen access.
    always_comb begin
        wr_en   = (acc == ACC_PUSH) || (acc == ACC_SWAP);
        wr_addr = (acc == ACC_PUSH) ? (sp - ONE) : sp;
        rd_en   = (acc == ACC_POP) || (acc == ACC_SWAP);
        rd_addr = sp;
        case (acc)
            ACC_PUSH: sp_nxt = sp - ONE;
            ACC_POP:  sp_nxt = sp + ONE;
            default:  sp_nxt = cfg_accept ? cfg_upper : sp;
        endcase
    end

    // Pointer register and registered exception pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp      <= SP_RST;
            ovf_exc <= 1'b0;
            udf_exc <= 1'b0;
        end else begin
            sp      <= sp_nxt;
            ovf_exc <= (acc == ACC_OVF);
            udf_exc <= (acc == ACC_UDF);
        end
    end

endmodule

// File: rtl/stack_mem.sv
// Module: stack_mem
// Single-write, single-read storage for the stack words with a registered
// read port. A read and a write to the same address in one cycle return the
// old word. Assumes the address range 0 .. 2**AW-1 is fully populated.
module stack_mem #(
    parameter int DW = 16,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Write port: no reset, contents are only meaningful once pushed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    // Registered read port with a one-cycle valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= store[rd_addr];
            end
        end
    end

endmodule

// File: rtl/hw_stack_lim.sv
// Module: hw_stack_lim (top)
// LIFO stack growing downward from a programmable top limit toward a bottom
// limit, with hardware overflow and underflow exceptions.
// Assumes a single clock domain and synchronous active-low reset.
module hw_stack_lim #(
    parameter int DW         = 16,
    parameter int AW         = 5,
    parameter int UPPER_INIT = (1 << AW) - 1,
    parameter int LOWER_INIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    output logic [DW-1:0] pop_data,
    output logic          pop_valid,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_upper,
    input  logic [AW-1:0] cfg_lower,
    output logic [AW-1:0] sp,
    output logic          full,
    output logic          empty,
    output logic          ovf_exc,
    output logic          udf_exc
);

    logic [AW-1:0] lim_upper;
    logic [AW-1:0] lim_lower;
    logic          cfg_accept;
    logic          busy;
    logic          wr_en;
    logic          rd_en;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;

    // A limit write must not coincide with any stack request.
    always_comb begin
        busy = push_req || pop_req;
    end

    stack_limits #(
        .AW(AW), .UPPER_INIT(UPPER_INIT), .LOWER_INIT(LOWER_INIT)
    ) u_limits (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .busy(busy),
        .cfg_upper(cfg_upper), .cfg_lower(cfg_lower),
        .upper(lim_upper), .lower(lim_lower), .cfg_accept(cfg_accept)
    );

    stack_ctrl #(
        .AW(AW), .UPPER_INIT(UPPER_INIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .upper(lim_upper), .lower(lim_lower), .cfg_accept(cfg_accept),
        .cfg_upper(cfg_upper), .sp(sp), .full(full), .empty(empty),
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
        .ovf_exc(ovf_exc), .udf_exc(udf_exc)
    );

    stack_mem #(
        .DW(DW), .AW(AW)
    ) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(push_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(pop_data), .rd_valid(pop_valid)
    );

endmodule

// File: rtl/hw_stack_lim_chk.sv
// Module: hw_stack_lim_chk
// Temporal checks on hw_stack_lim, attached to every instance by bind.
module hw_stack_lim_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_req,
    input logic          pop_req,
    input logic          cfg_we,
    input logic [AW-1:0] cfg_upper,
    input logic [AW-1:0] cfg_lower,
    input logic [AW-1:0] sp,
    input logic          full,
    input logic          empty,
    input logic          ovf_exc,
    input logic          udf_exc,
    input logic          pop_valid,
    input logic [AW-1:0] lim_upper,
    input logic [AW-1:0] lim_lower
);

    p_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && !full) |=> (sp == AW'($past(sp) - 1'b1)));

    p_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && !empty) |=> (pop_valid && sp == AW'($past(sp) + 1'b1)));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && full) |=> (ovf_exc && sp == $past(sp)));

    p_ovf_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_exc |=> !ovf_exc);

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty) |=> (udf_exc && !pop_valid && sp == $past(sp)));

    p_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sp >= lim_lower) && (sp <= lim_upper));

    p_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !empty) |=> (pop_valid && $stable(sp)));

    p_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !push_req && !pop_req && cfg_lower <= cfg_upper)
        |=> (sp == $past(cfg_upper) && empty));

    p_cfg_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (push_req || pop_req)) |=> $stable(lim_upper) && $stable(lim_lower));

    p_equal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_upper == lim_lower) |-> (full && empty));

    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_exc && udf_exc));

endmodule

bind hw_stack_lim hw_stack_lim_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .cfg_we(cfg_we), .cfg_upper(cfg_upper), .cfg_lower(cfg_lower),
    .sp(sp), .full(full), .empty(empty), .ovf_exc(ovf_exc),
    .udf_exc(udf_exc), .pop_valid(pop_valid),
    .lim_upper(lim_upper), .lim_lower(lim_lower)
);

// File: tb/test_hw_stack_lim.sv
`timescale 1ns/1ps
module test_hw_stack_lim;

    localparam int DW = 16;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_req = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic          pop_req = 1'b0;
    logic [DW-1:0] pop_data;
    logic          pop_valid;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_upper = '0;
    logic [AW-1:0] cfg_lower = '0;
    logic [AW-1:0] sp;
    logic          full;
    logic          empty;
    logic          ovf_exc;
    logic          udf_exc;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model state
    int            up_m = 31;
    int            lo_m = 0;
    int            sp_m = 31;
    logic [DW-1:0] model [$];
    logic [DW-1:0] exp_q [$];
    string         pend_tag [$];

    always #2.5 clk = ~clk;

    hw_stack_lim i_hw_stack_lim (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .pop_data(pop_data), .pop_valid(pop_valid),
        .cfg_we(cfg_we), .cfg_upper(cfg_upper), .cfg_lower(cfg_lower),
        .sp(sp), .full(full), .empty(empty), .ovf_exc(ovf_exc), .udf_exc(udf_exc)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compare each popped word with the scoreboard queue (R3, R7)
    always @(negedge clk) begin
        if (rst_n && pop_valid) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected pop_valid", 1, 0);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = pend_tag.pop_front();
                chk(t, int'(pop_data), int'(e));
            end
        end
    end

    // Driver: one cycle of stimulus plus model update and output checks
    task automatic op(input bit ps, input bit pp, input logic [DW-1:0] d,
                      input bit we, input int up, input int lo, input string tag);
        bit ex_ovf = 0;
        bit ex_udf = 0;
        bit ex_pv  = 0;
        bit m_full  = (sp_m == lo_m);
        bit m_empty = (sp_m == up_m);
        if (pp && m_empty) ex_udf = 1;
        else if (ps && !pp && m_full) ex_ovf = 1;
        else if (ps && pp) begin
            exp_q.push_back(model[model.size()-1]);
            pend_tag.push_back({tag, " swap data"});
            model[model.size()-1] = d;
            ex_pv = 1;
        end else if (ps) begin
            model.push_back(d);
            sp_m--;
        end else if (pp) begin
            exp_q.push_back(model.pop_back());
            pend_tag.push_back({tag, " pop data"});
            sp_m++;
            ex_pv = 1;
        end else if (we && lo <= up) begin
            up_m = up; lo_m = lo; sp_m = up;
            model.delete();
        end
        @(negedge clk);
        push_req = ps; pop_req = pp; push_data = d;
        cfg_we = we; cfg_upper = AW'(up); cfg_lower = AW'(lo);
        @(negedge clk);
        push_req = 0; pop_req = 0; cfg_we = 0;
        chk({tag, " sp"}, int'(sp), sp_m);
        chk({tag, " ovf_exc"}, int'(ovf_exc), int'(ex_ovf));
        chk({tag, " udf_exc"}, int'(udf_exc), int'(ex_udf));
        chk({tag, " pop_valid"}, int'(pop_valid), int'(ex_pv));
        chk({tag, " full R6"}, int'(full), int'(sp_m == lo_m));
        chk({tag, " empty R6"}, int'(empty), int'(sp_m == up_m));
    endtask

    task automatic push(input logic [DW-1:0] d, input string tag);
        op(1, 0, d, 0, 0, 0, tag);
    endtask

    task automatic pop(input string tag);
        op(0, 1, '0, 0, 0, 0, tag);
    endtask

    task automatic idle(input string tag);
        op(0, 0, '0, 0, 0, 0, tag);
    endtask

    task automatic setlim(input int up, input int lo, input string tag);
        op(0, 0, '0, 1, up, lo, tag);
    endtask

    // Watchdog
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            chk("watchdog expired", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 sp", int'(sp), 31);
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 ovf_exc", int'(ovf_exc), 0);
        chk("R1 udf_exc", int'(udf_exc), 0);
        chk("R1 pop_valid", int'(pop_valid), 0);

        // R5: pop while empty, then pulse must drop
        pop("R5 empty pop");
        idle("R5 pulse end");

        // R2, R3: LIFO order
        push(16'hA001, "R2 push1");
        push(16'hA002, "R2 push2");
        push(16'hA003, "R2 push3");
        pop("R3 pop3");
        push(16'hA004, "R2 push4");
        pop("R3 pop4");
        pop("R3 pop2");
        pop("R3 pop1");

        // R9: narrow region top=10 bottom=6, capacity 4 (R11)
        push(16'hBEEF, "R9 pre-write push");
        setlim(10, 6, "R9 limit write");
        for (int i = 0; i < 4; i++) push(DW'(16'hC000 + i), "R11 fill");
        // R4: overflow leaves contents and pointer alone
        push(16'hDEAD, "R4 overflow push");
        idle("R4 pulse end");
        for (int i = 0; i < 4; i++) pop("R4 contents intact");
        pop("R5 underflow after drain");

        // R7: swap on non-empty stack
        push(16'h1111, "R7 setup");
        push(16'h2222, "R7 setup");
        op(1, 1, 16'h3333, 0, 0, 0, "R7 swap");
        pop("R7 pop new");
        pop("R7 pop lower");

        // R8: swap on empty stack underflows, stores nothing
        op(1, 1, 16'h4444, 0, 0, 0, "R8 swap on empty");
        pop("R8 nothing stored");

        // R10: limit write with push in same cycle is ignored
        op(1, 0, 16'h5555, 1, 20, 2, "R10 write while busy");
        // R10: bottom above top is ignored
        setlim(8, 15, "R10 bottom above top");
        for (int i = 0; i < 4; i++) push(DW'(16'h6000 + i), "R10 old limits kept");
        for (int i = 0; i < 4; i++) pop("R10 drain");

        // R11: equal limits -> full and empty together
        setlim(12, 12, "R11 equal limits");
        push(16'h7777, "R11 push overflows");
        pop("R11 pop underflows");

        // Random run against the model across a wide region
        setlim(25, 3, "R9 wide region");
        for (int i = 0; i < 400; i++) begin
            int r = int'($urandom % 8);
            bit ps = (r < 4) || (r == 7);
            bit pp = (r >= 4);
            op(ps, pp, DW'($urandom), 0, 0, 0, "R3 random");
        end
        while (sp_m != up_m) pop("R3 final drain");
        idle("R6 settle");
        chk("R3 scoreboard empty", exp_q.size(), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule